// File: doc/BRIEF.md
# Cache-Block Access Checker and Store-Fault Mapper

This block sits beside the execution path of a cache-block management operation. It takes a byte address and rounds it down to the start of the cache block that contains it. The block size is two to the power of a build-time exponent. It hands that aligned address to an external translation stage. If translation succeeds, it hands the resulting physical address to an external permission stage, which reports separate read and write verdicts for the whole block.

The block gives the operation leave to proceed when either the read verdict or the write verdict allows it. In every failure case it reports one store-class cause code, so load-side faults are recast as their store-side counterparts. Each request ends with a one-cycle done strobe. On that cycle the block presents a fault flag, a cause code and the faulting virtual address, which is the aligned address.

Top module: `cblk_check`

## Requirements
- R1: `xlat_vaddr` equals the accepted `req_addr` with its low `BLK_EXP` bits cleared, and it stays unchanged from the cycle after acceptance until the done cycle.
- R2: `xlat_req` is high from the cycle after acceptance until the cycle in which `xlat_ack` is seen. `chk_req` rises only after a translation that did not fail. While `chk_req` is high, `chk_paddr` equals the `xlat_paddr` returned with the acknowledge, `chk_bytes` equals 2^`BLK_EXP`, and `xlat_req` and `chk_req` are never high together.
- R3: When the permission stage acknowledges with `rd_ok` or `wr_ok` high, the next cycle is a done cycle with `fault` low and `cause` zero.
- R4: When the permission stage acknowledges with both `rd_ok` and `wr_ok` low, the done cycle reports a fault whose cause comes from `wr_kind`.
- R5: A translation acknowledged with `xlat_fail` high produces a done cycle with `fault` high on the next cycle. `chk_req` is never raised for that request, and `rd_ok`/`wr_ok` have no effect on the result.
- R6: Fault kinds are 2-bit codes. Bit 1 set means a page fault and clear means an access fault. Bit 0 marks the store side. A fault reports cause 15 when bit 1 is set and cause 7 when it is clear; bit 0 has no effect on the cause.
- R7: `done` is high for exactly one cycle per request. On that cycle `fault_vaddr` equals the aligned address when `fault` is high. Outside the done cycle, `fault`, `cause` and `fault_vaddr` are zero.
- R8: `busy` is high from the cycle after acceptance through the done cycle. A `req_valid` seen while busy is dropped and not queued.
- R9: After reset the block is idle, and `busy`, `done`, `xlat_req`, `chk_req` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a check; taken only when idle |
| req_addr | input | ADDR_W | Unaligned base byte address |
| busy | output | 1 | A request is in progress |
| xlat_req | output | 1 | Translation request |
| xlat_vaddr | output | ADDR_W | Block-aligned virtual address |
| xlat_ack | input | 1 | Translation response valid |
| xlat_fail | input | 1 | Translation failed |
| xlat_kind | input | 2 | Translation fault kind (bit1 page, bit0 store) |
| xlat_paddr | input | ADDR_W | Translated physical address |
| chk_req | output | 1 | Permission check request |
| chk_paddr | output | ADDR_W | Physical block address to check |
| chk_bytes | output | BLK_EXP+1 | Size of the checked region in bytes |
| chk_ack | input | 1 | Permission response valid |
| rd_ok | input | 1 | Data read allowed on the block |
| wr_ok | input | 1 | Data write allowed on the block |
| wr_kind | input | 2 | Write-side fault kind (bit1 page, bit0 store) |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Request ended in a fault (valid with done) |
| cause | output | CAUSE_W | Store-class cause code (valid with done) |
| fault_vaddr | output | ADDR_W | Faulting virtual address (valid with done) |

## Verification
A corrupted state register would show up at once as an extra or missing `done` pulse, or as `xlat_req` and `chk_req` high together, one cycle after the bad transition. A wrong latched address or kind would show up as a bad `xlat_vaddr`, `chk_paddr` or `cause` on the next handshake or done cycle. The vector walk covers every kind code on both fault paths, read-only and write-only permission, and misaligned addresses at both ends of the range. Directed tests add reset, a request held high while busy, and a translation failure arriving with permissive check inputs.

// File: rtl/cblk_check.sv
module cblk_check #(
  parameter int ADDR_W  = 32,
  parameter int BLK_EXP = 6,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               busy,
  output logic               xlat_req,
  output logic [ADDR_W-1:0]  xlat_vaddr,
  input  logic               xlat_ack,
  input  logic               xlat_fail,
  input  logic [1:0]         xlat_kind,
  input  logic [ADDR_W-1:0]  xlat_paddr,
  output logic               chk_req,
  output logic [ADDR_W-1:0]  chk_paddr,
  output logic [BLK_EXP:0]   chk_bytes,
  input  logic               chk_ack,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic [1:0]         wr_kind,
  output logic               done,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic [ADDR_W-1:0]  fault_vaddr
);

  localparam logic [ADDR_W-1:0]  LOW_MASK  = ADDR_W'((64'd1 << BLK_EXP) - 64'd1);
  localparam logic [BLK_EXP:0]   BLK_BYTES = (BLK_EXP+1)'(1) << BLK_EXP;
  localparam logic [CAUSE_W-1:0] C_ST_ACC  = CAUSE_W'(7);
  localparam logic [CAUSE_W-1:0] C_ST_PAGE = CAUSE_W'(15);

  typedef enum logic [1:0] {S_IDLE, S_XLAT, S_CHK, S_DONE} state_t;

  state_t              st;
  logic [ADDR_W-1:0]   vaddr_q, paddr_q;
  logic                fault_q;
  logic [CAUSE_W-1:0]  cause_q;

  function automatic logic [CAUSE_W-1:0] to_store_cause(input logic [1:0] kind);
    case (kind)
      2'b00:   return C_ST_ACC;
      2'b01:   return C_ST_ACC;
      2'b10:   return C_ST_PAGE;
      default: return C_ST_PAGE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vaddr_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_XLAT;
          vaddr_q <= req_addr & ~LOW_MASK;
          fault_q <= 1'b0;
          cause_q <= '0;
        end
        S_XLAT: if (xlat_ack) begin
          if (xlat_fail) begin
            st      <= S_DONE;
            fault_q <= 1'b1;
            cause_q <= to_store_cause(xlat_kind);
          end else begin
            st      <= S_CHK;
            paddr_q <= xlat_paddr;
          end
        end
        S_CHK: if (chk_ack) begin
          st <= S_DONE;
          if (!(rd_ok || wr_ok)) begin
            fault_q <= 1'b1;
            cause_q <= to_store_cause(wr_kind);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign xlat_req    = (st == S_XLAT);
  assign xlat_vaddr  = vaddr_q;
  assign chk_req     = (st == S_CHK);
  assign chk_paddr   = paddr_q;
  assign chk_bytes   = BLK_BYTES;
  assign done        = (st == S_DONE);
  assign fault       = done & fault_q;
  assign cause       = fault ? cause_q : '0;
  assign fault_vaddr = fault ? vaddr_q : '0;

  assert_vaddr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(xlat_vaddr));

  assert_vaddr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((xlat_vaddr & LOW_MASK) == '0));

  assert_req_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlat_req && chk_req));

  assert_chk_after_good_xlat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_req) |-> $past(xlat_req && xlat_ack && !xlat_fail));

  assert_pass_on_either_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_ack && (rd_ok || wr_ok)) |=> (done && !fault));

  assert_fail_on_neither_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_ack && !rd_ok && !wr_ok) |=> (done && fault));

  assert_store_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (cause == C_ST_ACC || cause == C_ST_PAGE));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_covers_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

// File: tb/cblk_check_tb_top.sv
module cblk_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int BE = 6;
  localparam logic [AW-1:0] AMASK = ~((32'd1 << BE) - 32'd1);

  typedef struct packed {
    logic [31:0] addr;
    logic        xf;
    logic [1:0]  xk;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    logic [1:0]  wk;
    logic        ef;
    logic [4:0]  ec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    {32'h1000_0047, 1'b0, 2'b00, 32'h8000_0040, 1'b1, 1'b1, 2'b00, 1'b0, 5'd0},
    {32'h0000_007F, 1'b0, 2'b00, 32'h8000_1040, 1'b1, 1'b0, 2'b00, 1'b0, 5'd0},
    {32'h1234_5678, 1'b0, 2'b00, 32'h2000_0640, 1'b0, 1'b1, 2'b00, 1'b0, 5'd0},
    {32'hFFFF_FFFF, 1'b0, 2'b00, 32'h3000_0FC0, 1'b0, 1'b0, 2'b01, 1'b1, 5'd7},
    {32'h0000_0040, 1'b0, 2'b00, 32'h4000_0000, 1'b0, 1'b0, 2'b11, 1'b1, 5'd15},
    {32'hABCD_EF01, 1'b0, 2'b00, 32'h5000_0100, 1'b0, 1'b0, 2'b00, 1'b1, 5'd7},
    {32'h0000_0000, 1'b0, 2'b00, 32'h6000_0000, 1'b0, 1'b0, 2'b10, 1'b1, 5'd15},
    {32'h7FFF_FFC1, 1'b1, 2'b00, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 1'b1, 5'd7},
    {32'h8000_003F, 1'b1, 2'b10, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 1'b1, 5'd15},
    {32'h0101_0180, 1'b1, 2'b01, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 1'b1, 5'd7},
    {32'hDEAD_BEEF, 1'b1, 2'b11, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 1'b1, 5'd15},
    {32'h0000_1001, 1'b1, 2'b00, 32'h9000_0000, 1'b1, 1'b1, 2'b11, 1'b1, 5'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, xlat_req, chk_req, done, fault;
  logic [AW-1:0] xlat_vaddr, chk_paddr, fault_vaddr;
  logic [BE:0] chk_bytes;
  logic [4:0] cause;
  logic xlat_ack = 1'b0, xlat_fail = 1'b0;
  logic [1:0] xlat_kind = '0;
  logic [AW-1:0] xlat_paddr = '0;
  logic chk_ack = 1'b0, rd_ok = 1'b0, wr_ok = 1'b0;
  logic [1:0] wr_kind = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cblk_check #(.ADDR_W(AW), .BLK_EXP(BE), .CAUSE_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .xlat_req(xlat_req), .xlat_vaddr(xlat_vaddr),
    .xlat_ack(xlat_ack), .xlat_fail(xlat_fail), .xlat_kind(xlat_kind),
    .xlat_paddr(xlat_paddr), .chk_req(chk_req), .chk_paddr(chk_paddr),
    .chk_bytes(chk_bytes), .chk_ack(chk_ack), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .wr_kind(wr_kind), .done(done), .fault(fault), .cause(cause),
    .fault_vaddr(fault_vaddr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_one(input vec_t v, input bit hold_req);
    logic [31:0] al;
    al = v.addr & AMASK;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = v.addr;
    @(negedge clk);
    if (!hold_req) req_valid = 1'b0;
    else req_addr = ~v.addr;
    check("R8", "busy after accept", 32'(busy), 32'd1);
    check("R2", "xlat_req raised", 32'(xlat_req), 32'd1);
    check("R1", "aligned vaddr", xlat_vaddr, al);
    @(negedge clk);
    check("R2", "xlat_req held until ack", 32'(xlat_req), 32'd1);
    xlat_ack = 1'b1; xlat_fail = v.xf; xlat_kind = v.xk; xlat_paddr = v.pa;
    rd_ok = v.rd; wr_ok = v.wr; wr_kind = v.wk; chk_ack = v.xf;
    @(negedge clk);
    xlat_ack = 1'b0;
    if (!v.xf) begin
      check("R2", "chk_req after good translation", 32'(chk_req), 32'd1);
      check("R2", "xlat_req dropped", 32'(xlat_req), 32'd0);
      check("R2", "chk_paddr", chk_paddr, v.pa);
      check("R2", "chk_bytes", 32'(chk_bytes), 32'd64);
      check("R1", "vaddr held", xlat_vaddr, al);
      chk_ack = 1'b1;
      @(negedge clk);
    end else begin
      check("R5", "no permission phase", 32'(chk_req), 32'd0);
    end
    chk_ack = 1'b0;
    check("R7", "done strobe", 32'(done), 32'd1);
    check(v.xf ? "R5" : (v.ef ? "R4" : "R3"), "fault flag", 32'(fault), 32'(v.ef));
    check("R6", "cause", 32'(cause), 32'(v.ec));
    check("R7", "fault_vaddr", fault_vaddr, v.ef ? al : 32'd0);
    check("R8", "busy on done", 32'(busy), 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R7", "done single cycle", 32'(done), 32'd0);
    check("R7", "fault cleared after done", 32'(fault), 32'd0);
    check("R8", "idle after done, nothing queued", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "busy idle", 32'(busy), 32'd0);
    check("R9", "done idle", 32'(done), 32'd0);
    check("R9", "xlat_req idle", 32'(xlat_req), 32'd0);
    check("R9", "chk_req idle", 32'(chk_req), 32'd0);
    check("R9", "fault idle", 32'(fault), 32'd0);

    for (int i = 0; i < NV; i++) run_one(VEC[i], 1'b0);

    // R8: request held high with a different address while busy
    run_one(VEC[3], 1'b1);
    run_one(VEC[10], 1'b1);

    // R2: translation stage stalls several cycles
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0FFF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) begin
      check("R2", "xlat_req during stall", 32'(xlat_req), 32'd1);
      check("R8", "busy during stall", 32'(busy), 32'd1);
      @(negedge clk);
    end
    xlat_ack = 1'b1; xlat_fail = 1'b0; xlat_paddr = 32'hC000_0FC0;
    @(negedge clk);
    xlat_ack = 1'b0;
    check("R2", "chk_req after stall", 32'(chk_req), 32'd1);
    repeat (2) begin
      @(negedge clk);
      check("R2", "chk_req held until ack", 32'(chk_req), 32'd1);
    end
    chk_ack = 1'b1; rd_ok = 1'b1; wr_ok = 1'b0;
    @(negedge clk);
    chk_ack = 1'b0;
    check("R3", "read-only pass after stall", 32'(fault), 32'd0);
    check("R7", "done after stall", 32'(done), 32'd1);
    @(negedge clk);
    check("R8", "idle after stall", 32'(busy), 32'd0);

    // R9: reset in mid-request returns to idle
    req_valid = 1'b1; req_addr = 32'h1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9", "reset aborts request", 32'(busy), 32'd0);
    check("R9", "xlat_req after reset", 32'(xlat_req), 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all: watchdog expired, actual running expected finished");
    finish_run();
  end
endmodule